// File: doc/BRIEF.md
# Long-Pulse BREAK Symbol Timer

This block produces and recognises the BREAK symbol of a single-wire vehicle network, which is a deliberately long active pulse on the line. Its transmit half drives the pulse for a fixed number of microsecond ticks after a request. Its receive half measures every active pulse on the incoming line and flags the ones whose length falls between a lower and an upper limit. Data symbol coding, arbitration and CRC are handled elsewhere.

Durations are counted in ticks. A tick is one period of a prescaler that divides the system clock by (setting + 1). Software rewrites the setting to match the clock rate, or to stretch symbol timing. Each half has its own prescaler, and that prescaler restarts on the edge that opens a pulse, so lengths are exact multiples of the tick period rather than depending on the tick phase. The line is active high on both sides.

Top module: `brk_sym_unit`

## Requirements
- R1: After reset, `tx_line_o`, `tx_done_o` and `brk_seen_o` are all 0.
- R2: A `send_brk_i` high in a clock cycle while no BREAK is in progress drives `tx_line_o` high from the next cycle. It stays high for exactly TX_LEN_US ticks, which is TX_LEN_US*(presc_i+1) clock cycles. The default of 300 ticks lies within the 280-tick minimum and the 5000-tick ceiling.
- R3: `tx_done_o` is high for exactly one cycle, the first cycle in which `tx_line_o` is low again after a BREAK.
- R4: A `send_brk_i` that arrives while a BREAK is being driven has no effect. The pulse neither restarts nor lengthens, and no second BREAK follows it.
- R5: One tick lasts presc_i+1 clock cycles. A new presc_i value scales the length of every later symbol, both the sent pulse and the receive measurement.
- R6: `rx_line_i` passes through two flip-flops before measurement. A high pulse of H clock cycles is measured as floor(H/(presc_i+1)) ticks.
- R7: When a measured pulse qualifies, `brk_seen_o` is high for exactly one cycle. That cycle is sampled two rising clock edges after `rx_line_i` falls, and no other pulse of `brk_seen_o` occurs.
- R8: A pulse measured at fewer than RX_MIN_US ticks (default 239) raises no `brk_seen_o`. A pulse of exactly RX_MIN_US ticks does raise it.
- R9: A pulse measured at more than RX_MAX_US ticks (default 1,000,000, which is 1 s) raises no `brk_seen_o`. A pulse of exactly RX_MAX_US ticks does raise it. The width counter saturates just above that limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_i | input | PRESC_W | Tick divider setting; tick = presc_i+1 cycles |
| send_brk_i | input | 1 | Request to transmit one BREAK |
| rx_line_i | input | 1 | Receive line, active high, asynchronous |
| tx_line_o | output | 1 | Transmit line, high while a BREAK is driven |
| tx_done_o | output | 1 | One-cycle pulse as the BREAK ends |
| brk_seen_o | output | 1 | One-cycle pulse for a received BREAK |

## Verification
A wrong tick count or a tick phase that is not restarted would show at once as a transmit pulse one or more ticks off its expected cycle count. The bench therefore counts the high cycles exactly for several prescaler settings. On the receive side, a width counter that is off by one shows up only at the classification boundaries. Pulses exactly at and one cycle across each limit are therefore driven alongside random widths, and the detect flag is checked in the exact cycle it should appear and in the cycles on either side of it.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_DRIVE = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    // true when a measured width lies inside [lo, hi]
    function automatic logic width_in_window(input int unsigned w,
                                             input int unsigned lo,
                                             input int unsigned hi);
        return (w >= lo) && (w <= hi);
    endfunction

endpackage

// File: rtl/brk_tick.sv
module brk_tick #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);
    logic [PRESC_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= presc_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/brk_tx.sv
module brk_tx
    import brk_pkg::*;
#(
    parameter int TX_LEN_US = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic req_i,
    output logic start_o,
    output logic line_o,
    output logic done_o
);
    localparam int LW = $clog2(TX_LEN_US + 1);

    tx_state_e      state_q;
    logic [LW-1:0]  len_q;

    assign start_o = (state_q == TX_IDLE) && req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            len_q   <= '0;
            line_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                TX_IDLE: begin
                    if (req_i) begin
                        state_q <= TX_DRIVE;
                        line_o  <= 1'b1;
                        len_q   <= '0;
                    end
                end
                default: begin
                    if (tick_i) begin
                        if (len_q == LW'(TX_LEN_US - 1)) begin
                            state_q <= TX_IDLE;
                            line_o  <= 1'b0;
                            done_o  <= 1'b1;
                        end else begin
                            len_q <= len_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R2: an idle request puts the pulse on the line in the next cycle
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (req_i && !line_o) |=> line_o);

    // R2: tick count never runs past the programmed length while driving
    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_DRIVE) |-> (len_q < LW'(TX_LEN_US)));

    // R3: completion flag accompanies the end of the pulse
    p_done_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(line_o) |-> done_o);

    // R4: without a tick the pulse cannot end or restart
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (line_o && !tick_i) |=> (line_o && $stable(len_q)));
endmodule

// File: rtl/brk_rx.sv
module brk_rx
    import brk_pkg::*;
#(
    parameter int RX_MIN_US = 239,
    parameter int RX_MAX_US = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic line_i,
    output logic restart_o,
    output logic det_o
);
    localparam int CW  = $clog2(RX_MAX_US + 2);
    localparam int SAT = RX_MAX_US + 1;

    sync_t          sy_q;
    logic [CW-1:0]  wcnt_q;
    logic [CW-1:0]  wcnt_nxt;
    logic           fall;

    assign restart_o = sy_q.s1 && !sy_q.s2;
    assign fall      = !sy_q.s1 && sy_q.s2;

    always_comb begin
        wcnt_nxt = wcnt_q;
        if (sy_q.s2 && tick_i && (wcnt_q < CW'(SAT))) begin
            wcnt_nxt = wcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sy_q   <= '0;
            wcnt_q <= '0;
            det_o  <= 1'b0;
        end else begin
            sy_q.s1 <= line_i;
            sy_q.s2 <= sy_q.s1;
            det_o   <= 1'b0;
            if (restart_o) begin
                wcnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_nxt;
            end
            if (fall) begin
                det_o <= width_in_window(int'(wcnt_nxt), RX_MIN_US, RX_MAX_US);
            end
        end
    end

    // R7: a detection only follows the end of a synchronised pulse
    p_det_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
        det_o |-> $past(fall));

    // R7: detection is a single-cycle pulse
    p_det_single_r7: assert property (@(posedge clk) disable iff (rst)
        det_o |=> !det_o);

    // R9: width counter saturates just above the upper limit
    p_wcnt_sat_r9: assert property (@(posedge clk) disable iff (rst)
        wcnt_q <= CW'(SAT));

    // R6: the counter only advances while the synchronised line is high
    p_count_when_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!sy_q.s2 && !restart_o) |=> $stable(wcnt_q));
endmodule

// File: rtl/brk_sym_unit.sv
module brk_sym_unit #(
    parameter int PRESC_W   = 8,
    parameter int TX_LEN_US = 300,
    parameter int RX_MIN_US = 239,
    parameter int RX_MAX_US = 1000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               send_brk_i,
    input  logic               rx_line_i,
    output logic               tx_line_o,
    output logic               tx_done_o,
    output logic               brk_seen_o
);
    logic tx_tick, tx_start;
    logic rx_tick, rx_restart;

    brk_tick #(.PRESC_W(PRESC_W)) u_tx_tick (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (tx_start),
        .presc_i (presc_i),
        .tick_o  (tx_tick)
    );

    brk_tx #(.TX_LEN_US(TX_LEN_US)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tx_tick),
        .req_i   (send_brk_i),
        .start_o (tx_start),
        .line_o  (tx_line_o),
        .done_o  (tx_done_o)
    );

    brk_tick #(.PRESC_W(PRESC_W)) u_rx_tick (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (rx_restart),
        .presc_i (presc_i),
        .tick_o  (rx_tick)
    );

    brk_rx #(.RX_MIN_US(RX_MIN_US), .RX_MAX_US(RX_MAX_US)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (rx_tick),
        .line_i    (rx_line_i),
        .restart_o (rx_restart),
        .det_o     (brk_seen_o)
    );

    // R1: all outputs quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!tx_line_o && !tx_done_o && !brk_seen_o));
endmodule

// File: tb/brk_sym_unit_bench.sv
module brk_sym_unit_bench;
    localparam int PW     = 8;
    localparam int TXLEN  = 300;
    localparam int RXMIN  = 239;
    localparam int RXMAX  = 600;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] presc = '0;
    logic          send_brk = 1'b0;
    logic          rx_line = 1'b0;
    logic          tx_line, tx_done, brk_seen;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    brk_sym_unit #(.PRESC_W(PW), .TX_LEN_US(TXLEN), .RX_MIN_US(RXMIN),
                   .RX_MAX_US(RXMAX)) u_brk_sym_unit (
        .clk        (clk),
        .rst        (rst),
        .presc_i    (presc),
        .send_brk_i (send_brk),
        .rx_line_i  (rx_line),
        .tx_line_o  (tx_line),
        .tx_done_o  (tx_done),
        .brk_seen_o (brk_seen)
    );

    function automatic int exp_tx_cycles(input int p);
        return TXLEN * (p + 1);
    endfunction

    function automatic logic exp_det(input int h, input int p);
        int n;
        n = h / (p + 1);
        return (n >= RXMIN) && (n <= RXMAX);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_one(input int p, input bit inject);
        int cnt;
        int done_err;
        @(negedge clk);
        presc = PW'(p);
        repeat (3) @(negedge clk);
        send_brk = 1'b1;
        @(negedge clk);
        send_brk = 1'b0;
        chk(tx_line == 1'b1, "R2 line rises after request", int'(tx_line), 1);
        cnt = 0;
        done_err = 0;
        while (tx_line && cnt < 20000) begin
            cnt++;
            if (tx_done) done_err++;
            send_brk = (inject && (cnt == 50 || cnt == exp_tx_cycles(p) - 1));
            @(negedge clk);
        end
        send_brk = 1'b0;
        if (inject)
            chk(cnt == exp_tx_cycles(p), "R4 request during BREAK ignored", cnt, exp_tx_cycles(p));
        else
            chk(cnt == exp_tx_cycles(p), "R2/R5 BREAK length", cnt, exp_tx_cycles(p));
        chk(done_err == 0, "R3 no done while driving", done_err, 0);
        chk(tx_done == 1'b1, "R3 done on first low cycle", int'(tx_done), 1);
        @(negedge clk);
        chk(tx_done == 1'b0, "R3 done lasts one cycle", int'(tx_done), 0);
        chk(tx_line == 1'b0, "R4 no second BREAK", int'(tx_line), 0);
    endtask

    task automatic recv_one(input int h, input int p, input string req);
        logic e;
        int early;
        e = exp_det(h, p);
        @(negedge clk);
        presc = PW'(p);
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        early = 0;
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            if (brk_seen) early++;
        end
        rx_line = 1'b0;
        @(negedge clk);
        if (brk_seen) early++;
        chk(early == 0, "R7 no flag before fall", early, 0);
        @(negedge clk);
        chk(brk_seen == e, req, int'(brk_seen), int'(e));
        @(negedge clk);
        chk(brk_seen == 1'b0, "R7 flag lasts one cycle", int'(brk_seen), 0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        int p, h;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(!tx_line && !tx_done && !brk_seen, "R1 reset state",
            int'({tx_line, tx_done, brk_seen}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_line && !tx_done && !brk_seen, "R1 quiet after reset",
            int'({tx_line, tx_done, brk_seen}), 0);

        // transmit: several prescaler settings, R5 stretch
        send_one(0, 1'b0);
        send_one(1, 1'b0);
        send_one(3, 1'b0);
        send_one(2, 1'b1);

        // receive boundaries, R6 R8 R9
        recv_one(RXMIN * 1,     0, "R8 exactly minimum detected");
        recv_one(RXMIN * 1 - 1, 0, "R8 one tick short rejected");
        recv_one(RXMIN * 3,     2, "R6 minimum at presc 2");
        recv_one(RXMIN * 3 - 1, 2, "R6 floor below minimum");
        recv_one(RXMAX * 2 + 1, 1, "R9 exactly maximum detected");
        recv_one((RXMAX + 1) * 2, 1, "R9 over maximum rejected");
        recv_one(RXMAX * 3, 0, "R9 saturated width rejected");
        recv_one(5, 0, "R8 short glitch rejected");

        // random widths around the window
        for (int k = 0; k < 20; k++) begin
            p = int'($urandom % 3);
            h = (200 + int'($urandom % 460)) * (p + 1) + int'($urandom % (p + 1));
            recv_one(h, p, "R7 random pulse classification");
        end
        for (int k = 0; k < 3; k++) begin
            p = int'($urandom % 4);
            send_one(p, k[0]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule